// File: doc/BRIEF.md
# Keyed Watchdog Timer with One-Shot Configuration

This block is a system watchdog. A 12-bit down-counter is decremented on a slow time base: the slow-clock enable `slow_tick` is divided by a prescaler, 128 by default, which gives a 256 Hz count rate from a 32.768 kHz source. If software does not restart the counter before it passes zero, the block fires a reset pulse. The pulse goes either to the whole system or only to the processor.

The block is configured through a single write to a setup register. The first write after reset is taken, and every later write is dropped. That write can disable the watchdog, freeze it while a debugger holds the core, choose the reset target, and set a restart window. A restart only takes effect when the command register write carries the right key. A restart also counts as legal only when the counter has already fallen to or below the window limit. An early restart is flagged as an error and, when resets are enabled, it fires a reset. Once counting, no register access can stop the timer.

Top module: `wdog_lock_timer`

## Requirements
- R1: The counter decrements by exactly one on every PRESCALE-th pulse of `slow_tick` (a 4096-tick maximum period at 12 bits).
- R2: When a count tick arrives with the counter at 0, the underflow flag (status bit 16) sets and the counter reloads from the configured reload value, so a reload value V gives V+1 ticks per period.
- R3: The setup register (address 1) accepts only the first write after reset, and that write also reloads the counter from its new reload field. Every later write leaves the setup register and the counter unchanged. The setup fields are: reload [11:0], window limit [23:12], reset enable [24], processor-only [25], debug freeze [26], disable [27].
- R4: A write to the command register (address 0) with 0xA5 in bits [31:24] and bit 0 set is a restart. When legal, it reloads the counter from the reload value.
- R5: A command write with any other key, or with bit 0 clear, has no effect on the counter or the flags.
- R6: A restart is legal only when the counter is at or below the window limit. An illegal restart leaves the counter unchanged and sets the error flag (status bit 17). A limit of 0xFFF therefore allows a restart at any count.
- R7: With reset enable set, an underflow or an illegal restart produces a PULSE_LEN-cycle pulse. The pulse goes on `sys_rst_o` when processor-only is clear and on `cpu_rst_o` when it is set. With reset enable clear, neither output pulses.
- R8: With the disable bit set, the counter never changes, no reset fires, and the bit reads back as 1 at address 1.
- R9: After reset, the counter holds 0xFFF, the setup register reads 0x01FFFFFF (counting, reset enabled, full window, system target), both flags are 0, and the setup register is open for its single write.
- R10: A read of the status register (address 2) returns {error[17], underflow[16], counter[11:0]} and clears both flags. A flag event in the same cycle as the read wins over the clear.
- R11: With debug freeze set and `dbg_i` high, the counter holds its value across count ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| dbg_i | input | 1 | Debugger holds the processor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flags) |
| addr | input | 2 | Register select: 0 command, 1 setup, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| sys_rst_o | output | 1 | System reset pulse |
| cpu_rst_o | output | 1 | Processor-only reset pulse |

## Verification
The hardest cases to reach are the ones that depend on the one-shot setup. Once the setup register is locked, the disable, processor-only and reset-disabled settings cannot be reached in the same run. The stimulus therefore applies `rst_n` again between scenarios and spends each single setup write on one configuration. The early-restart error also needs the counter to sit above a narrow window limit at the moment of the command. The bench uses a small prescaler and counts whole tick groups, so the counter value is known exactly, and then issues the keyed restart one tick before the counter enters the window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 12;
  localparam logic [7:0] RESTART_KEY = 8'hA5;

  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_SETUP = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  typedef struct packed {
    logic             dis;
    logic             dbg_frz;
    logic             cpu_only;
    logic             rst_en;
    logic [CNT_W-1:0] win;
    logic [CNT_W-1:0] reload;
  } setup_t;

  localparam setup_t SETUP_RESET = '{dis: 1'b0, dbg_frz: 1'b0, cpu_only: 1'b0,
                                     rst_en: 1'b1, win: '1, reload: '1};

  function automatic setup_t setup_from_word(input logic [31:0] w);
    return setup_t'(w[27:0]);
  endfunction

  function automatic logic [31:0] setup_to_word(input setup_t s);
    return {4'b0000, s};
  endfunction

  function automatic logic is_restart(input logic [31:0] w);
    return (w[31:24] == RESTART_KEY) && w[0];
  endfunction

  function automatic logic in_window(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] win);
    return cnt <= win;
  endfunction

  function automatic logic [31:0] status_word(input logic err, input logic uf,
                                              input logic [CNT_W-1:0] cnt);
    return {14'b0, err, uf, 4'b0000, cnt};
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = slow_tick && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else if (slow_tick) pre_q <= pre_q + 1'b1;
  end

  assert_prescale_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tick && !tick) |=> (pre_q == $past(pre_q) + 1'b1));
  assert_prescale_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         freeze,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         underflow
);
  logic step;

  assign step      = tick && !freeze && !load;
  assign underflow = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '1;
    else if (load)      cnt <= load_val;
    else if (underflow) cnt <= reload_val;
    else if (step)      cnt <= cnt - 1'b1;
  end

  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_frozen_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !load) |=> (cnt == $past(cnt)));
  assert_reload_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic to_cpu,
  output logic sys_rst_o,
  output logic cpu_rst_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;
  logic          cpu_q;
  logic          active;

  assign active    = (left_q != '0);
  assign sys_rst_o = active && !cpu_q;
  assign cpu_rst_o = active && cpu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      cpu_q  <= 1'b0;
    end else if (fire) begin
      left_q <= LW'(LEN);
      cpu_q  <= to_cpu;
    end else if (active) begin
      left_q <= left_q - 1'b1;
    end
  end

  assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (sys_rst_o || cpu_rst_o));
  assert_pulse_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cpu_rst_o == $past(to_cpu)));
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_rst_o, cpu_rst_o}));
endmodule

// File: rtl/wdog_lock_timer.sv
module wdog_lock_timer #(
  parameter int PRESCALE  = 128,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        dbg_i,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sys_rst_o,
  output logic        cpu_rst_o
);
  import wdog_pkg::*;

  setup_t            setup_q;
  setup_t            setup_new;
  logic              locked_q;
  logic              setup_take;
  logic              cmd_wr;
  logic              restart_req;
  logic              restart_ok;
  logic              restart_bad;
  logic              stat_rd;
  logic              tick;
  logic              freeze;
  logic              cnt_load;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  cnt;
  logic              uf_ev;
  logic              fire;
  logic              uf_q;
  logic              err_q;

  // register access decode
  assign setup_new   = setup_from_word(wdata);
  assign setup_take  = wr_en && (addr == ADDR_SETUP) && !locked_q;
  assign cmd_wr      = wr_en && (addr == ADDR_CMD);
  assign restart_req = cmd_wr && is_restart(wdata) && !setup_q.dis;
  assign restart_ok  = restart_req && in_window(cnt, setup_q.win);
  assign restart_bad = restart_req && !in_window(cnt, setup_q.win);
  assign stat_rd     = rd_en && (addr == ADDR_STAT);

  // counter control
  assign freeze   = setup_q.dis || (setup_q.dbg_frz && dbg_i);
  assign cnt_load = setup_take || restart_ok;
  assign load_val = setup_take ? setup_new.reload : setup_q.reload;
  assign fire     = setup_q.rst_en && (uf_ev || restart_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= SETUP_RESET;
      locked_q <= 1'b0;
    end else if (setup_take) begin
      setup_q  <= setup_new;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (uf_ev)            uf_q <= 1'b1;
      else if (stat_rd)     uf_q <= 1'b0;
      if (restart_bad)      err_q <= 1'b1;
      else if (stat_rd)     err_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_SETUP: rdata = setup_to_word(setup_q);
      ADDR_STAT:  rdata = status_word(err_q, uf_q, cnt);
      default:    rdata = '0;
    endcase
  end

  wdog_prescale #(.DIV(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wdog_downcount #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .freeze     (freeze),
    .load       (cnt_load),
    .load_val   (load_val),
    .reload_val (setup_q.reload),
    .cnt        (cnt),
    .underflow  (uf_ev)
  );

  wdog_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .to_cpu    (setup_q.cpu_only),
    .sys_rst_o (sys_rst_o),
    .cpu_rst_o (cpu_rst_o)
  );

  assert_setup_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(setup_q));
  assert_uf_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uf_ev |=> uf_q);
  assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_bad |=> (err_q && cnt == $past(cnt)));
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !uf_ev && !restart_bad) |=> (!uf_q && !err_q));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_q.dis |-> !fire);
  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !is_restart(wdata) && !tick) |=> (cnt == $past(cnt)));
endmodule

// File: tb/wdog_lock_timer_test.sv
`timescale 1ns/1ps
module wdog_lock_timer_test;
  localparam int PRE = 4;
  localparam int PL  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        dbg_i = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst_o;
  logic        cpu_rst_o;

  wdog_lock_timer #(.PRESCALE(PRE), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .dbg_i(dbg_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int sys_seen = 0;
  int cpu_seen = 0;

  always @(posedge clk) begin
    if (sys_rst_o) sys_seen <= sys_seen + 1;
    if (cpu_rst_o) cpu_seen <= cpu_seen + 1;
  end

  // scoreboard
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t       sbq[$];
  logic [31:0] obs;
  event        obs_ev;

  initial forever begin
    @(obs_ev);
    if (sbq.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard empty: actual %h expected none", obs);
    end else begin
      item_t it;
      it = sbq.pop_front();
      n_cmp++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic sb_check(input logic [31:0] actual, input logic [31:0] exp,
                          input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    obs = actual;
    ->obs_ev;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [31:0] exp,
                        input string tag);
    logic [31:0] v;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
    sb_check(v, exp, tag);
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    slow(n * PRE);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] stat(input logic err, input logic uf,
                                       input int cnt);
    return (32'(err) << 17) | (32'(uf) << 16) | (32'(cnt) & 32'hFFF);
  endfunction

  task automatic settle_pulses(input int sys_exp, input int cpu_exp,
                               input string tag);
    repeat (PL + 4) @(negedge clk);
    sb_check(32'(sys_seen), 32'(sys_exp), {tag, " sys pulse cycles"});
    sb_check(32'(cpu_seen), 32'(cpu_exp), {tag, " cpu pulse cycles"});
    sys_seen = 0; cpu_seen = 0;
  endtask

  localparam logic [31:0] GOOD = 32'hA500_0001;

  initial begin
    do_reset();
    sys_seen = 0; cpu_seen = 0;
    // R9 reset state
    reg_rd(2'd2, stat(0, 0, 12'hFFF), "R9 status after reset");
    reg_rd(2'd1, 32'h01FF_FFFF, "R9 setup after reset");
    // R1 prescaler: 3 slow ticks no change, 4th decrements
    slow(PRE - 1);
    reg_rd(2'd2, stat(0, 0, 12'hFFF), "R1 before full prescale");
    slow(1);
    reg_rd(2'd2, stat(0, 0, 12'hFFE), "R1 after full prescale");
    // R5 wrong key and missing restart bit
    reg_wr(2'd0, 32'h5A00_0001);
    reg_wr(2'd0, 32'hA500_0000);
    reg_rd(2'd2, stat(0, 0, 12'hFFE), "R5 bad command ignored");
    // R4/R6 keyed restart, full window
    reg_wr(2'd0, GOOD);
    reg_rd(2'd2, stat(0, 0, 12'hFFF), "R4 restart reloads");
    // R3 first setup write: reload 5, window 3, reset en, debug freeze
    reg_wr(2'd1, 32'h0500_3005);
    reg_rd(2'd1, 32'h0500_3005, "R3 setup taken");
    reg_rd(2'd2, stat(0, 0, 5), "R3 setup reloads counter");
    // R3 second write ignored (tries to disable and change reload)
    reg_wr(2'd1, 32'h0DFF_F00F);
    reg_rd(2'd1, 32'h0500_3005, "R3 second write ignored");
    ticks(1);
    reg_rd(2'd2, stat(0, 0, 4), "R3 still counting after ignored write");
    // R6/R7 early restart at 4 > window 3
    sys_seen = 0; cpu_seen = 0;
    reg_wr(2'd0, GOOD);
    reg_rd(2'd2, stat(1, 0, 4), "R6 early restart flags error, no reload");
    reg_rd(2'd2, stat(0, 0, 4), "R10 read cleared error");
    settle_pulses(PL, 0, "R7 early restart");
    // R6 legal restart at 3
    ticks(1);
    reg_wr(2'd0, GOOD);
    reg_rd(2'd2, stat(0, 0, 5), "R6 restart inside window");
    // R11 debug freeze
    dbg_i = 1'b1;
    ticks(2);
    reg_rd(2'd2, stat(0, 0, 5), "R11 frozen under debug");
    dbg_i = 1'b0;
    // R2/R7 underflow: 5 ticks to 0, one more underflows (V+1 period)
    sys_seen = 0; cpu_seen = 0;
    ticks(5);
    reg_rd(2'd2, stat(0, 0, 0), "R2 counter reached zero");
    sb_check(32'(sys_seen), 32'd0, "R2 no reset before underflow");
    ticks(1);
    reg_rd(2'd2, stat(0, 1, 5), "R2 underflow flag and reload");
    reg_rd(2'd2, stat(0, 0, 5), "R10 read cleared underflow");
    settle_pulses(PL, 0, "R7 underflow");

    // R8 disable through the single write
    do_reset();
    sys_seen = 0; cpu_seen = 0;
    reg_wr(2'd1, 32'h09FF_F007);
    reg_rd(2'd1, 32'h09FF_F007, "R8 disable bit reads back");
    ticks(10);
    reg_wr(2'd0, GOOD);
    reg_rd(2'd2, stat(0, 0, 7), "R8 disabled counter holds");
    settle_pulses(0, 0, "R8 disabled");

    // R7 processor-only target
    do_reset();
    sys_seen = 0; cpu_seen = 0;
    reg_wr(2'd1, 32'h03FF_F002);
    ticks(3);
    reg_rd(2'd2, stat(0, 1, 2), "R7 cpu-only underflow");
    settle_pulses(0, PL, "R7 cpu-only");

    // R7 reset enable clear: flags only
    do_reset();
    sys_seen = 0; cpu_seen = 0;
    reg_wr(2'd1, 32'h0000_0001);
    reg_wr(2'd0, GOOD);
    ticks(2);
    reg_rd(2'd2, stat(1, 1, 1), "R7 reset disabled, flags still set");
    settle_pulses(0, 0, "R7 reset disabled");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule